// File: doc/BRIEF.md
# Digital Auto-Fine-Tuning Search Controller

After a channel change this block hunts for the best local-oscillator setting. It takes the stored frequency word for the channel, backs off below it, waits for the tuner to settle, and then raises the word step by step. Each decision uses a three-level tuning-error indication that is sampled on a 10 ms tick, together with a sync-present flag that is debounced inside the block.

The search runs in three speeds. A coarse phase moves quickly until the error reads high. A medium phase creeps up until the error falls back into the low band. A fine phase then walks up in single units until the error sits in the middle band. Losing sync in the medium or fine phase sends the search back to the coarse phase. The search gives up if the word climbs too far above the stored value or if too many steps have been taken. When it gives up, it restores the stored word and raises an abort flag.

Every change of the word is announced by a one-cycle load strobe, which the tuner bus logic uses to send the new divider setting. One frequency unit is 50 kHz.

Top module: `aft_search_ctrl`

## Requirements
- R1: After reset, freq_o is 0 and load_o, done_o and abort_o are all low.
- R2: One cycle after start_i, freq_o equals stored_freq_i minus BACKOFF (20 units), load_o is high, and done_o and abort_o are low. A start pulse restarts the search from this point in any phase, including the tick timing.
- R3: The first evaluation happens on the SETTLE_TICKS-th tick (24) after start, and freq_o does not change before it. If level_i reads low (2'b00) at that evaluation the search enters the fine phase; any other code enters the coarse phase. The evaluation itself does not change the word.
- R4: In the coarse phase, every STEP_TICKS-th tick (4) the block checks level_i. If it reads high (2'b10) the search moves to the medium phase with no step; otherwise freq_o rises by 10 units.
- R5: In the medium phase, every 4th tick the block checks level_i. If it reads low (2'b00) the search moves to the fine phase with no step; otherwise, including the between-bands code 2'b11, freq_o rises by 2 units.
- R6: In the fine phase, every 4th tick the block checks level_i. If it reads middle (2'b01) the search ends: done_o rises, the word is left unchanged and there is no load. Otherwise freq_o rises by 1 unit.
- R7: sync_raw_i is sampled on every second tick, and a new value is accepted only after two consecutive samples agree. If the accepted sync is absent at a medium-phase or fine-phase evaluation, the search returns to the coarse phase with no step. The coarse phase ignores sync.
- R8: If a step would bring the word to stored_freq_i + CEIL (30 units) or higher, freq_o is set back to the stored word, load_o pulses, abort_o rises and the search stops.
- R9: If a step would be the MAX_STEPS-th step since start, freq_o is set back to the stored word, load_o pulses, abort_o rises and the search stops.
- R10: freq_o changes only in a cycle where load_o is high, and load_o stays high for one cycle per change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts or restarts the search |
| stored_freq_i | input | FW | Stored frequency word of the channel (at least BACKOFF) |
| level_i | input | 2 | Tuning-error band: 00 low, 01 middle, 10 high, 11 between bands |
| sync_raw_i | input | 1 | Raw sync-present reading |
| tick_i | input | 1 | One-cycle pulse every 10 ms |
| freq_o | output | FW | Current frequency word |
| load_o | output | 1 | One-cycle strobe on every change of freq_o |
| done_o | output | 1 | Search ended on the middle band |
| abort_o | output | 1 | Search gave up and restored the stored word |

## Verification
Every result of this block is due exactly one clock after the edge that carries its cause. The reload appears one cycle after start_i. An evaluation's step, phase change, done or abort appears one cycle after the clock edge that samples the deciding tick. The bench drives start_i and tick_i on falling edges and reads the outputs on the next falling edge, so the strobe is seen in its one cycle and the word is read after it has settled. Phase changes that leave the word untouched are confirmed by the size of the next step (10, 2 or 1 units).

// File: rtl/aft_pkg.sv
package aft_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_COARSE,
    PH_MID,
    PH_FINE
  } phase_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_GAP  = 2'b11
  } level_e;
endpackage

// File: rtl/aft_sync_filter.sv
module aft_sync_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  logic phase_q, last_q, filt_q, sample;

  assign sample = tick_i && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      last_q  <= 1'b0;
      filt_q  <= 1'b0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
      if (sample) begin
        last_q <= raw_i;
        if (raw_i == last_q) filt_q <= raw_i;
      end
    end
  end

  assign filt_o = filt_q;

  // accepted value only ever moves to a value just sampled
  assert_accept_matches_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(raw_i) && $past(sample)));
endmodule

// File: rtl/aft_interval_timer.sv
module aft_interval_timer #(
  parameter int SETTLE_TICKS = 24,
  parameter int STEP_TICKS   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  input  logic long_i,
  output logic fire_o
);
  localparam int MAXT = (SETTLE_TICKS > STEP_TICKS) ? SETTLE_TICKS : STEP_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(SETTLE_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(STEP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == (long_i ? LONG_LAST : SHORT_LAST));
  assign fire_o  = tick_i && at_last && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  assert_count_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LONG_LAST || cnt_q <= SHORT_LAST);
endmodule

// File: rtl/aft_step_calc.sv
module aft_step_calc
  import aft_pkg::*;
#(
  parameter int FW         = 15,
  parameter int CEIL       = 30,
  parameter int MAX_STEPS  = 100,
  parameter int COARSE_INC = 10,
  parameter int MID_INC    = 2,
  parameter int FINE_INC   = 1,
  parameter int SW         = 7
) (
  input  phase_e          phase_i,
  input  logic [FW-1:0]   freq_i,
  input  logic [FW-1:0]   base_i,
  input  logic [SW-1:0]   steps_i,
  output logic [FW-1:0]   nxt_o,
  output logic            over_o
);
  localparam logic [SW-1:0] LAST_STEP = SW'(MAX_STEPS - 1);

  logic [FW-1:0] inc;
  logic [FW:0]   sum, limit;

  always_comb begin
    case (phase_i)
      PH_COARSE: inc = FW'(COARSE_INC);
      PH_MID:    inc = FW'(MID_INC);
      default:   inc = FW'(FINE_INC);
    endcase
    sum    = {1'b0, freq_i} + {1'b0, inc};
    limit  = {1'b0, base_i} + (FW+1)'(CEIL);
    nxt_o  = sum[FW-1:0];
    over_o = (sum >= limit) || (steps_i >= LAST_STEP);
  end
endmodule

// File: rtl/aft_search_ctrl.sv
module aft_search_ctrl
  import aft_pkg::*;
#(
  parameter int FW           = 15,
  parameter int BACKOFF      = 20,
  parameter int CEIL         = 30,
  parameter int MAX_STEPS    = 100,
  parameter int SETTLE_TICKS = 24,
  parameter int STEP_TICKS   = 4,
  parameter int COARSE_INC   = 10,
  parameter int MID_INC      = 2,
  parameter int FINE_INC     = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] stored_freq_i,
  input  logic [1:0]    level_i,
  input  logic          sync_raw_i,
  input  logic          tick_i,
  output logic [FW-1:0] freq_o,
  output logic          load_o,
  output logic          done_o,
  output logic          abort_o
);
  localparam int SW = $clog2(MAX_STEPS + 1);

  phase_e        phase_q, phase_d;
  logic [FW-1:0] freq_q, base_q, nxt_freq;
  logic [SW-1:0] steps_q;
  logic          load_q, done_q, abort_q;
  logic          sync_ok, fire, over, take_step, finish;

  aft_sync_filter u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .raw_i  (sync_raw_i),
    .filt_o (sync_ok)
  );

  aft_interval_timer #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .STEP_TICKS   (STEP_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i || phase_q == PH_IDLE),
    .tick_i  (tick_i),
    .long_i  (phase_q == PH_SETTLE),
    .fire_o  (fire)
  );

  aft_step_calc #(
    .FW         (FW),
    .CEIL       (CEIL),
    .MAX_STEPS  (MAX_STEPS),
    .COARSE_INC (COARSE_INC),
    .MID_INC    (MID_INC),
    .FINE_INC   (FINE_INC),
    .SW         (SW)
  ) u_step (
    .phase_i (phase_q),
    .freq_i  (freq_q),
    .base_i  (base_q),
    .steps_i (steps_q),
    .nxt_o   (nxt_freq),
    .over_o  (over)
  );

  always_comb begin
    phase_d   = phase_q;
    take_step = 1'b0;
    finish    = 1'b0;
    if (fire) begin
      case (phase_q)
        PH_SETTLE: phase_d = (level_i == LVL_LOW) ? PH_FINE : PH_COARSE;
        PH_COARSE: begin
          if (level_i == LVL_HIGH) phase_d = PH_MID;
          else                     take_step = 1'b1;
        end
        PH_MID: begin
          if (!sync_ok)                 phase_d = PH_COARSE;
          else if (level_i == LVL_LOW)  phase_d = PH_FINE;
          else                          take_step = 1'b1;
        end
        PH_FINE: begin
          if (!sync_ok) phase_d = PH_COARSE;
          else if (level_i == LVL_MID) begin
            finish  = 1'b1;
            phase_d = PH_IDLE;
          end else take_step = 1'b1;
        end
        default: ;
      endcase
    end
    if (take_step && over) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      freq_q  <= '0;
      base_q  <= '0;
      steps_q <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_SETTLE;
      base_q  <= stored_freq_i;
      freq_q  <= stored_freq_i - FW'(BACKOFF);
      steps_q <= '0;
      load_q  <= 1'b1;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      load_q  <= take_step;
      if (finish) done_q <= 1'b1;
      if (take_step) begin
        if (over) begin
          freq_q  <= base_q;
          abort_q <= 1'b1;
        end else begin
          freq_q  <= nxt_freq;
          steps_q <= steps_q + SW'(1);
        end
      end
    end
  end

  assign freq_o  = freq_q;
  assign load_o  = load_q;
  assign done_o  = done_q;
  assign abort_o = abort_q;

  assert_start_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (load_o && !done_o && !abort_o &&
                 freq_o == $past(stored_freq_i - FW'(BACKOFF))));

  assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!load_o && $stable(freq_o) && !abort_o));

  assert_abort_restores_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (load_o && freq_o == base_q && !done_o));

  assert_step_budget_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q < SW'(MAX_STEPS));

  assert_change_has_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(freq_o));
endmodule

// File: tb/aft_search_ctrl_tb.sv
module aft_search_ctrl_tb;
  localparam int FW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, tick, sync_raw;
  logic [1:0]    level;
  logic [FW-1:0] stored;
  logic [FW-1:0] freq, freq_l;
  logic          load, done, abort, load_l, done_l, abort_l;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  aft_search_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stored_freq_i(stored),
    .level_i(level), .sync_raw_i(sync_raw), .tick_i(tick),
    .freq_o(freq), .load_o(load), .done_o(done), .abort_o(abort)
  );

  aft_search_ctrl #(.MAX_STEPS(3)) u_dut_lim (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stored_freq_i(stored),
    .level_i(level), .sync_raw_i(sync_raw), .tick_i(tick),
    .freq_o(freq_l), .load_o(load_l), .done_o(done_l), .abort_o(abort_l)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int f, input int ld, input int dn, input int ab);
    chk({tag, " freq"}, int'(freq), f);
    chk({tag, " load"}, int'(load), ld);
    chk({tag, " done"}, int'(done), dn);
    chk({tag, " abort"}, int'(abort), ab);
  endtask

  task automatic do_start(input int s);
    stored = FW'(s);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk_all("R2 reload", s - 20, 1, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic test_main();
    level = 2'b01;
    do_start(2000);
    ticks(23);
    chk_all("R3 settle hold", 1980, 0, 0, 0);
    ticks(1);
    chk_all("R3 first eval no step", 1980, 0, 0, 0);
    ticks(3);
    chk_all("R4 between evals", 1980, 0, 0, 0);
    ticks(1);
    chk_all("R4 coarse step", 1990, 1, 0, 0);
    @(negedge clk);
    chk("R10 strobe one cycle", int'(load), 0);
    level = 2'b10;
    ticks(4);
    chk_all("R4 high enters mid", 1990, 0, 0, 0);
    level = 2'b01;
    ticks(4);
    chk_all("R5 mid step", 1992, 1, 0, 0);
    level = 2'b11;
    ticks(4);
    chk_all("R5 mid step on gap", 1994, 1, 0, 0);
    level = 2'b00;
    ticks(4);
    chk_all("R5 low enters fine", 1994, 0, 0, 0);
    ticks(4);
    chk_all("R6 fine step on low", 1995, 1, 0, 0);
    level = 2'b10;
    ticks(4);
    chk_all("R6 fine step on high", 1996, 1, 0, 0);
    level = 2'b01;
    ticks(4);
    chk_all("R6 done on middle", 1996, 0, 1, 0);
    ticks(8);
    chk_all("R6 idle after done", 1996, 0, 1, 0);
  endtask

  task automatic test_direct_fine();
    level = 2'b00;
    do_start(500);
    ticks(24);
    chk_all("R3 low goes to fine", 480, 0, 0, 0);
    ticks(4);
    chk_all("R3 fine step size", 481, 1, 0, 0);
    level = 2'b01;
    ticks(4);
    chk_all("R6 done", 481, 0, 1, 0);
  endtask

  task automatic test_ceiling();
    level = 2'b01;
    do_start(3000);
    ticks(24);
    ticks(12);
    chk_all("R4 coarse run", 3010, 1, 0, 0);
    ticks(4);
    chk_all("R8 below ceiling", 3020, 1, 0, 0);
    ticks(4);
    chk_all("R8 ceiling restore", 3000, 1, 0, 1);
    ticks(8);
    chk_all("R8 stopped", 3000, 0, 0, 1);
  endtask

  task automatic test_iter_limit();
    level = 2'b11;
    do_start(1000);
    ticks(24);
    ticks(4);
    chk("R4 gap coarse step", int'(freq), 990);
    chk("R9 lim first step", int'(freq_l), 990);
    ticks(4);
    chk("R9 lim second step", int'(freq_l), 1000);
    ticks(4);
    chk("R9 default keeps going", int'(freq), 1010);
    chk("R9 default no abort", int'(abort), 0);
    chk("R9 lim restored", int'(freq_l), 1000);
    chk("R9 lim abort", int'(abort_l), 1);
    chk("R9 lim load", int'(load_l), 1);
    chk("R9 lim not done", int'(done_l), 0);
  endtask

  task automatic test_sync_loss();
    level = 2'b11;
    do_start(1000);
    ticks(24);
    sync_raw = 1'b0;
    ticks(8);
    chk_all("R7 coarse ignores sync", 1000, 1, 0, 0);
    level = 2'b10;
    ticks(4);
    chk_all("R7 enter mid", 1000, 0, 0, 0);
    level = 2'b01;
    ticks(4);
    chk_all("R7 sync lost back to coarse", 1000, 0, 0, 0);
    level = 2'b11;
    ticks(4);
    chk_all("R7 coarse step after loss", 1010, 1, 0, 0);
    sync_raw = 1'b1;
    ticks(4);
    chk_all("R7 coarse continues", 1020, 1, 0, 0);
  endtask

  task automatic test_restart();
    level = 2'b01;
    do_start(4000);
    ticks(24);
    ticks(4);
    chk_all("R2 pre restart", 3990, 1, 0, 0);
    ticks(2);
    level = 2'b00;
    do_start(5000);
    ticks(23);
    chk_all("R2 settle restarted", 4980, 0, 0, 0);
    ticks(1);
    chk_all("R2 eval after restart", 4980, 0, 0, 0);
    level = 2'b11;
    ticks(4);
    chk_all("R2 fine after restart", 4981, 1, 0, 0);
    level = 2'b01;
    ticks(4);
    chk_all("R2 done after restart", 4981, 0, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tick = 1'b0; level = 2'b01;
    sync_raw = 1'b1; stored = '0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 0, 0, 0, 0);
    test_main();
    test_direct_fine();
    test_ceiling();
    test_iter_limit();
    test_sync_loss();
    test_restart();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule